// File: doc/BRIEF.md
# Triggered Ten-Tap Pulse Sequencer

This block turns a single trigger into a train of ten single-cycle pulses, each on its own output bit. The trigger may change at any time relative to the clock. The block passes it through a synchronizer and starts a sequence only on a rising edge. After each interval of N clock cycles, the next tap output pulses. Tap 1 comes first and tap 10 comes last, so one sequence lasts 10·N cycles.

A busy flag covers the whole sequence. While it is high, further trigger edges are ignored, so a trigger that comes too early cannot corrupt a running train. The spacing N comes from a build-time parameter. A select input can replace it with a value from a port. That value is captured when the sequence starts.

Top module: `tap_sequencer`

## Requirements
- R1: While rst_ni is low and after reset is released, tap_o is all zero and busy_o is low until a trigger edge is detected.
- R2: Let clock edge k be the first rising clock edge at which trig_i is high after being low. Tap j (j = 1..10) is high during exactly one cycle: the cycle that follows clock edge k+1+j·N.
- R3: Bit i of tap_o (bit 0 = LSB) is tap i+1. At most one bit is high at any time, and within a sequence the bits fire in ascending order, each exactly once.
- R4: busy_o rises in the cycle after edge k+2 and stays high through the cycle in which tap 10 pulses. It is low in the next cycle. tap_o is zero whenever busy_o is low.
- R5: A rising edge of trig_i that is detected while busy_o is high is ignored. The running sequence is unchanged and no new sequence follows.
- R6: Only a low-to-high transition starts a sequence. If trig_i stays high past the end of a sequence, no new sequence starts.
- R7: When spacing_ovr_i is low, N equals the SPACING parameter. When spacing_ovr_i is high, N equals spacing_i. Either value is captured at the start of the sequence, and later changes to spacing_i or spacing_ovr_i do not affect the running sequence.
- R8: An override value of 0 is treated as N = 1. With N = 1 the ten taps pulse on ten consecutive cycles.
- R9: With the default SPACING of 250, consecutive taps are 250 cycles apart and tap 10 comes 2500 cycles after the detected edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Trigger, asynchronous to clk_i |
| spacing_ovr_i | input | 1 | Use spacing_i instead of the SPACING parameter |
| spacing_i | input | CNT_W | Run-time tap spacing in clock cycles |
| busy_o | output | 1 | Sequence in progress |
| tap_o | output | NUM_TAPS | One-cycle tap pulses, bit 0 = first tap |

## Verification
The sequencer is run with the default spacing of 250 and with override spacings of 0, 1, 2 and random values. Comparing these runs shows that the parameter and port paths are separate and that the zero-to-one clamp works. Each run is checked on every cycle against a computed timeline of all ten taps and the busy flag, so an error in the first-tap latency, the spacing or the order shows up. Some runs add a second trigger pulse during busy, hold the trigger high past the end of the sequence, or change spacing_i mid-sequence. These runs show that retriggers, level triggers and late spacing changes are ignored.

// File: rtl/tap_seq_pkg.sv
package tap_seq_pkg;
  localparam int unsigned TAP_COUNT = 10;
  localparam int unsigned DEF_SPACING = 250;
  localparam int unsigned DEF_CNT_W = 16;
endpackage

// File: rtl/tap_trig_sync.sv
module tap_trig_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= trig_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/tap_timer.sv
module tap_timer #(
  parameter int unsigned NUM_TAPS = 10,
  parameter int unsigned CNT_W    = 16,
  localparam int unsigned IDX_W   = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] n_i,
  output logic             busy_o,
  output logic             fire_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q, n_q;
  logic [IDX_W-1:0] idx_q;
  logic             last;

  always_comb begin
    fire_o = busy_q && (cnt_q == '0);
    last   = (idx_q == IDX_W'(NUM_TAPS - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      n_q    <= '0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        n_q    <= n_i;
        cnt_q  <= n_i - CNT_W'(1);
      end
    end else if (fire_o) begin
      if (last) begin
        busy_q <= 1'b0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
        cnt_q <= n_q - CNT_W'(1);
      end
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/tap_onehot.sv
module tap_onehot #(
  parameter int unsigned NUM_TAPS = 10,
  localparam int unsigned IDX_W   = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
  input  logic                fire_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [NUM_TAPS-1:0] tap_o
);
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    assign tap_o[i] = fire_i && (idx_i == IDX_W'(i));
  end
endmodule

// File: rtl/tap_sequencer.sv
module tap_sequencer
  import tap_seq_pkg::*;
#(
  parameter int unsigned NUM_TAPS = TAP_COUNT,
  parameter int unsigned SPACING  = DEF_SPACING,
  parameter int unsigned CNT_W    = DEF_CNT_W,
  localparam int unsigned IDX_W   = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                trig_i,
  input  logic                spacing_ovr_i,
  input  logic [CNT_W-1:0]    spacing_i,
  output logic                busy_o,
  output logic [NUM_TAPS-1:0] tap_o
);
  logic             rise;
  logic             fire;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] n_sel, n_eff;

  always_comb begin
    n_sel = spacing_ovr_i ? spacing_i : CNT_W'(SPACING);
    n_eff = (n_sel == '0) ? CNT_W'(1) : n_sel;
  end

  tap_trig_sync u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(trig_i),
    .rise_o(rise)
  );

  tap_timer #(.NUM_TAPS(NUM_TAPS), .CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(rise),
    .n_i    (n_eff),
    .busy_o (busy_o),
    .fire_o (fire),
    .idx_o  (idx)
  );

  tap_onehot #(.NUM_TAPS(NUM_TAPS)) u_dec (
    .fire_i(fire),
    .idx_i (idx),
    .tap_o (tap_o)
  );
endmodule

// File: rtl/tap_seq_chk.sv
module tap_seq_chk #(
  parameter int unsigned NUM_TAPS = 10,
  localparam int unsigned IDX_W   = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                busy_o,
  input logic [NUM_TAPS-1:0] tap_o
);
  logic [IDX_W-1:0] exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            exp_q <= '0;
    else if (!busy_o)       exp_q <= '0;
    else if (tap_o != '0)   exp_q <= exp_q + IDX_W'(1);
  end

  AST_TAP_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tap_o)); // R3

  AST_TAP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_o != '0) |-> (tap_o == (NUM_TAPS'(1) << exp_q))); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (tap_o == '0)); // R4

  AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_o[NUM_TAPS-1] |=> !busy_o); // R4

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_pw
    AST_TAP_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tap_o[i] |=> !tap_o[i]); // R2
  end
endmodule

bind tap_sequencer tap_seq_chk #(.NUM_TAPS(NUM_TAPS)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .busy_o(busy_o),
  .tap_o (tap_o)
);

// File: tb/sim_tap_sequencer.sv
`timescale 1ns/1ps
module sim_tap_sequencer;
  localparam int NT = 10;
  localparam int CW = 16;
  localparam int DEF_N = 250;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic trig = 1'b0;
  logic ovr = 1'b0;
  logic [CW-1:0] spc = '0;
  logic busy;
  logic [NT-1:0] tap;
  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  tap_sequencer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .trig_i(trig), .spacing_ovr_i(ovr),
    .spacing_i(spc), .busy_o(busy), .tap_o(tap)
  );

  function automatic logic [NT-1:0] exp_tap(int n, int m);
    int d;
    d = m - 2;
    if (d >= n && d % n == 0 && d / n <= NT) return NT'(1) << (d / n - 1);
    return '0;
  endfunction

  function automatic logic exp_busy(int n, int m);
    return (m >= 3) && (m <= 2 + NT * n);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // Starts a sequence at a negedge; hold = cycles trig stays high,
  // rt = edge count after which a retrigger pulse is driven (0 = none),
  // chg = change spacing inputs after start.
  task automatic run_seq(string req, int n, int hold, int rt, bit chg);
    int m;
    int ntap, nbusy;
    trig = 1'b1;
    ntap = 0; nbusy = 0;
    for (m = 1; m <= NT * n + 12; m++) begin
      @(negedge clk);
      if (exp_tap(n, m) !== tap || exp_busy(n, m) !== busy) begin
        check({req, " tap"}, 32'(tap), 32'(exp_tap(n, m)));
        check({req, " busy"}, 32'(busy), 32'(exp_busy(n, m)));
      end
      if (tap != '0) ntap++;
      if (busy) nbusy++;
      if (m == hold) trig = 1'b0;
      if (rt != 0 && m == rt) trig = 1'b1;
      if (rt != 0 && m == rt + 2) trig = 1'b0;
      if (chg && m == 4) begin spc = spc + CW'(3); ovr = ~ovr; end
    end
    check({req, " tap count"}, 32'(ntap), 32'(NT));
    check({req, " busy length"}, 32'(nbusy), 32'(NT * n));
    trig = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    @(negedge clk);
    check("R1 reset tap", 32'(tap), 0);
    check("R1 reset busy", 32'(busy), 0);
    trig = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 trig ignored in reset", 32'(tap | NT'(busy)), 0);
    trig = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle after reset", 32'(busy), 0);

    // default spacing
    run_seq("R9 R2 default N", DEF_N, 2, 0, 1'b0);
    // override N=1 and 0 clamp
    ovr = 1'b1; spc = CW'(1);
    run_seq("R8 N=1", 1, 1, 0, 1'b0);
    spc = '0;
    run_seq("R8 zero clamps", 1, 1, 0, 1'b0);
    spc = CW'(2);
    run_seq("R7 override N=2", 2, 3, 0, 1'b0);
    // retrigger during busy
    spc = CW'(5);
    run_seq("R5 retrigger", 5, 2, 20, 1'b0);
    // retrigger right near the end of the busy window
    spc = CW'(4);
    run_seq("R5 late retrigger", 4, 2, NT * 4, 1'b0);
    // level held beyond end
    spc = CW'(3);
    run_seq("R6 held level", 3, NT * 3 + 10, 0, 1'b0);
    // spacing change mid-run
    spc = CW'(7);
    run_seq("R7 mid-run change", 7, 2, 0, 1'b1);
    // constrained random runs
    for (int i = 0; i < 30; i++) begin
      int n, h, r;
      n = 1 + int'($urandom_range(19));
      h = 1 + int'($urandom_range(4));
      r = ($urandom_range(1) == 1) ? h + 3 + int'($urandom_range(NT * n - 1)) : 0;
      if (r > NT * n) r = 0;
      ovr = 1'b1; spc = CW'(n);
      run_seq("R2 R3 R4 random", n, h, r, 1'b0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule